// File: doc/BRIEF.md
# Buffered Two-Way Merge Node

This block is one node of a binary merge tree. It accepts two ascending key streams, each from a child node or from a run store, and delivers one ascending stream to its parent. Every input lands in a small buffer cell of its own. Because of that cell, the ready signal a node returns upstream depends only on its own fill level. The ready from downstream never reaches it through logic. Each node can therefore act on every clock cycle without a stall path running through the whole tree.

The streams are split into runs by marker beats. The node merges one run from the left input with one run from the right input. When one side reaches its marker it drains the other side, then sends one marker of its own and moves on to the next pair of runs. After reset the output stays quiet for a short warm-up once both inputs first hold data. This mirrors a tree that comes online one layer at a time. Several nodes are wired together to build a tree, and the bench builds a small two-level one.

Top module: `mtn_node`

## Requirements
- R1: After reset, before any input beat is accepted, `o_valid` is low and both `a_ready` and `b_ready` are high.
- R2: Within a run pair, the output keys are all keys of both input runs, each exactly once, in ascending unsigned order.
- R3: Each input buffer holds 2×KPC beats (2 by default). Its ready is low exactly while it is full. A beat offered while ready is low is accepted later, neither lost nor duplicated.
- R4: When both head keys are equal, the left (`a`) input is consumed first. With both buffers full of equal keys, a single output transfer frees a slot on `a` only: `a_ready` rises and `b_ready` stays low.
- R5: A beat with `*_eor`=1 is a run marker and its key field is ignored. After both inputs present their marker, the node emits exactly one marker beat (`o_eor`=1, `o_key`=0) and consumes both input markers. Until then it drains the input that has not yet reached its marker. Keys of the next run pair follow that marker and are never mixed into the previous run.
- R6: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_key` and `o_eor` hold their values on the next cycle, and no input beat is consumed.
- R7: After reset, once both input buffers first hold a beat, `o_valid` stays low for WARMUP (default 2) further cycles. When both inputs are accepted on the same edge E, `o_valid` is low after E and after E+1, and first high after E+2.
- R8: Nodes compose: a two-level tree of three nodes fed by four run streams produces, for each run, the ascending merge of all four runs followed by a single marker. This holds under random gaps on the inputs and random backpressure at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Left input beat present |
| a_ready | output | 1 | Left buffer can take a beat |
| a_key | input | KEY_W*KPC | Left input key |
| a_eor | input | 1 | Left beat is a run marker |
| b_valid | input | 1 | Right input beat present |
| b_ready | output | 1 | Right buffer can take a beat |
| b_key | input | KEY_W*KPC | Right input key |
| b_eor | input | 1 | Right beat is a run marker |
| o_valid | output | 1 | Output beat present |
| o_ready | input | 1 | Parent accepts the output beat |
| o_key | output | KEY_W*KPC | Output key (0 on a marker) |
| o_eor | output | 1 | Output beat is a run marker |

## Verification
Several directed runs come first:
- Runs interleaved key by key separate a correct comparison from one that merely alternates between the inputs.
- Runs where one side ends long before the other expose a node that stops at the first marker or emits two markers.
- Back-to-back run pairs, where a small key follows a large one across the marker, reveal runs leaking into each other.
- Keys at 0 and all-ones probe the unsigned compare.
- Buffers filled with equal keys and released by a single transfer show which side wins a tie, and pushing into a full buffer shows whether beats are held or lost.

Random run lengths with many repeated keys, random input gaps and random output backpressure are then applied to one node and to a three-node tree. This shows whether the handshakes keep every key exactly once when layers stall independently.

// File: rtl/mtn_pkg.sv
package mtn_pkg;

   // Which head the node forwards this cycle.
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_A    = 2'd1,
      SEL_B    = 2'd2,
      SEL_MARK = 2'd3
   } sel_e;

   // Decide the forwarded head from head presence, marker flags and
   // the precomputed "left key not greater than right key" bit.
   function automatic sel_e pick_head(input logic a_hv, input logic a_he,
                                      input logic b_hv, input logic b_he,
                                      input logic a_le_b);
      sel_e s;
      s = SEL_NONE;
      if (a_hv && b_hv) begin
         if (a_he && b_he)      s = SEL_MARK;
         else if (a_he)         s = SEL_B;
         else if (b_he)         s = SEL_A;
         else if (a_le_b)       s = SEL_A;
         else                   s = SEL_B;
      end
      return s;
   endfunction

endpackage

// File: rtl/mtn_buf_cell.sv
module mtn_buf_cell #(
   parameter int W     = 33,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         hd_valid,
   output logic [W-1:0] hd_data,
   input  logic         pop
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt_q;
   logic          push;
   logic          take;

   assign in_ready = (cnt_q < CW'(DEPTH));
   assign push     = in_valid && in_ready;
   assign hd_valid = (cnt_q != '0);
   assign take     = pop && hd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({push, take})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   generate
      if (DEPTH == 2) begin : g_pair
         // Two-register variant: slot0 is always the head.
         logic [W-1:0] s0_q, s1_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s0_q <= '0;
               s1_q <= '0;
            end else begin
               case ({push, take})
                  2'b10: begin
                     if (cnt_q == '0) s0_q <= in_data;
                     else             s1_q <= in_data;
                  end
                  2'b01: s0_q <= s1_q;
                  2'b11: begin
                     if (cnt_q == CW'(1)) begin
                        s0_q <= in_data;
                     end else begin
                        s0_q <= s1_q;
                        s1_q <= in_data;
                     end
                  end
                  default: ;
               endcase
            end
         end
         assign hd_data = s0_q;
      end else begin : g_ring
         // General ring variant for other depths.
         localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wp_q, rp_q;

         function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q <= '0;
               rp_q <= '0;
            end else begin
               if (push) wp_q <= nxt(wp_q);
               if (take) rp_q <= nxt(rp_q);
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem_q[wp_q] <= in_data;
         end
         assign hd_data = mem_q[rp_q];
      end
   endgenerate

endmodule

// File: rtl/mtn_warmup.sv
module mtn_warmup #(
   parameter int CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic en
);
   generate
      if (CYCLES == 0) begin : g_none
         assign en = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q != CW'(CYCLES)) begin
               // Once started, keeps counting even if start drops.
               if (start || cnt_q != '0) cnt_q <= cnt_q + 1'b1;
            end
         end
         assign en = (cnt_q == CW'(CYCLES));
      end
   endgenerate
endmodule

// File: rtl/mtn_select.sv
module mtn_select import mtn_pkg::*; #(
   parameter int KW = 32
) (
   input  logic          a_hv,
   input  logic          a_he,
   input  logic [KW-1:0] a_hk,
   input  logic          b_hv,
   input  logic          b_he,
   input  logic [KW-1:0] b_hk,
   output sel_e          sel,
   output logic [KW-1:0] key
);
   logic a_le_b;

   // Unsigned compare; equality favours the left side.
   assign a_le_b = (a_hk <= b_hk);
   assign sel    = pick_head(a_hv, a_he, b_hv, b_he, a_le_b);

   always_comb begin
      case (sel)
         SEL_A:   key = a_hk;
         SEL_B:   key = b_hk;
         default: key = '0;
      endcase
   end
endmodule

// File: rtl/mtn_node.sv
module mtn_node import mtn_pkg::*; #(
   parameter int KEY_W    = 32,
   parameter int KPC      = 1,
   parameter int BUF_MULT = 2,
   parameter int WARMUP   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 a_valid,
   output logic                 a_ready,
   input  logic [KEY_W*KPC-1:0] a_key,
   input  logic                 a_eor,
   input  logic                 b_valid,
   output logic                 b_ready,
   input  logic [KEY_W*KPC-1:0] b_key,
   input  logic                 b_eor,
   output logic                 o_valid,
   input  logic                 o_ready,
   output logic [KEY_W*KPC-1:0] o_key,
   output logic                 o_eor
);
   localparam int KW    = KEY_W * KPC;
   localparam int DEPTH = BUF_MULT * KPC;
   localparam int BW    = KW + 1;

   generate
      if (KEY_W < 1)    begin : g_bad_w   $error("mtn_node: KEY_W must be positive");  end
      if (KPC != 1)     begin : g_bad_kpc $error("mtn_node: only one key per cycle");  end
      if (BUF_MULT < 1) begin : g_bad_buf $error("mtn_node: BUF_MULT must be >= 1");   end
      if (WARMUP < 0)   begin : g_bad_wu  $error("mtn_node: WARMUP must be >= 0");     end
   endgenerate

   logic          in_v  [2];
   logic          in_r  [2];
   logic [BW-1:0] in_d  [2];
   logic          hd_v  [2];
   logic [BW-1:0] hd_d  [2];
   logic          pop   [2];

   assign in_v[0] = a_valid;
   assign in_v[1] = b_valid;
   assign in_d[0] = {a_eor, a_key};
   assign in_d[1] = {b_eor, b_key};
   assign a_ready = in_r[0];
   assign b_ready = in_r[1];

   generate
      for (genvar i = 0; i < 2; i++) begin : g_side
         mtn_buf_cell #(.W(BW), .DEPTH(DEPTH)) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_v[i]),
            .in_ready (in_r[i]),
            .in_data  (in_d[i]),
            .hd_valid (hd_v[i]),
            .hd_data  (hd_d[i]),
            .pop      (pop[i])
         );
      end
   endgenerate

   logic          warm;
   sel_e          sel;
   logic [KW-1:0] sel_key;
   logic          fire;
   logic          pop_a, pop_b;

   mtn_warmup #(.CYCLES(WARMUP)) warm_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (hd_v[0] && hd_v[1]),
      .en    (warm)
   );

   mtn_select #(.KW(KW)) sel_i (
      .a_hv (hd_v[0]),
      .a_he (hd_d[0][KW]),
      .a_hk (hd_d[0][KW-1:0]),
      .b_hv (hd_v[1]),
      .b_he (hd_d[1][KW]),
      .b_hk (hd_d[1][KW-1:0]),
      .sel  (sel),
      .key  (sel_key)
   );

   assign o_valid = warm && (sel != SEL_NONE);
   assign o_key   = sel_key;
   assign o_eor   = (sel == SEL_MARK);
   assign fire    = o_valid && o_ready;

   assign pop_a  = fire && (sel == SEL_A || sel == SEL_MARK);
   assign pop_b  = fire && (sel == SEL_B || sel == SEL_MARK);
   assign pop[0] = pop_a;
   assign pop[1] = pop_b;

endmodule

// File: rtl/mtn_node_chk.sv
module mtn_node_chk #(
   parameter int KW     = 32,
   parameter int DEPTH  = 2,
   parameter int WARMUP = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a_valid,
   input logic          a_ready,
   input logic          b_valid,
   input logic          b_ready,
   input logic          a_eor,
   input logic          b_eor,
   input logic          o_valid,
   input logic          o_ready,
   input logic [KW-1:0] o_key,
   input logic          o_eor,
   input logic          pop_a,
   input logic          pop_b
);
   logic          a_fire, b_fire, o_fire;
   logic [15:0]   occ_a, occ_b;
   logic [15:0]   mk_a, mk_b, mk_o;
   logic          have_last;
   logic [KW-1:0] last_key;
   logic          seen_a, seen_b;
   logic [15:0]   wcnt;

   assign a_fire = a_valid && a_ready;
   assign b_fire = b_valid && b_ready;
   assign o_fire = o_valid && o_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_a <= '0; occ_b <= '0;
         mk_a <= '0; mk_b <= '0; mk_o <= '0;
         have_last <= 1'b0; last_key <= '0;
         seen_a <= 1'b0; seen_b <= 1'b0; wcnt <= '0;
      end else begin
         occ_a <= occ_a + {15'd0, a_fire} - {15'd0, pop_a};
         occ_b <= occ_b + {15'd0, b_fire} - {15'd0, pop_b};
         if (a_fire && a_eor) mk_a <= mk_a + 1'b1;
         if (b_fire && b_eor) mk_b <= mk_b + 1'b1;
         if (o_fire && o_eor) mk_o <= mk_o + 1'b1;
         if (o_fire) begin
            have_last <= !o_eor;
            last_key  <= o_key;
         end
         if (a_fire) seen_a <= 1'b1;
         if (b_fire) seen_b <= 1'b1;
         if (seen_a && seen_b && wcnt < 16'(WARMUP)) wcnt <= wcnt + 1'b1;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> !o_valid && a_ready && b_ready);

   assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && !o_eor && have_last |-> o_key >= last_key);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ_a <= 16'(DEPTH) && occ_b <= 16'(DEPTH));

   assert_ready_low_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_ready |-> occ_a == 16'(DEPTH)) and (!b_ready |-> occ_b == 16'(DEPTH)));

   assert_single_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
      o_fire && o_eor |-> mk_a > mk_o && mk_b > mk_o);

   assert_hold_when_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && !o_ready |=> o_valid && $stable(o_key) && $stable(o_eor));

   assert_no_pop_when_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !o_ready |-> !pop_a && !pop_b);

   assert_warmup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> wcnt >= 16'(WARMUP));

endmodule

bind mtn_node mtn_node_chk #(.KW(KEY_W*KPC), .DEPTH(BUF_MULT*KPC), .WARMUP(WARMUP)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_valid (a_valid),
   .a_ready (a_ready),
   .b_valid (b_valid),
   .b_ready (b_ready),
   .a_eor   (a_eor),
   .b_eor   (b_eor),
   .o_valid (o_valid),
   .o_ready (o_ready),
   .o_key   (o_key),
   .o_eor   (o_eor),
   .pop_a   (pop_a),
   .pop_b   (pop_b)
);

// File: tb/mtn_node_tb_top.sv
`timescale 1ns/1ps
module mtn_node_tb_top;
   localparam int KW = 32;
   localparam logic [KW:0] MARK = {1'b1, {KW{1'b0}}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;

   // Stream drivers: 0,1 feed the single node, 2..5 feed the tree leaves.
   logic          dv  [6];
   logic [KW-1:0] dk  [6];
   logic          de  [6];
   logic          rdy [6];
   bit            rlat[6];
   logic [KW:0]   dq  [6][$];
   bit            gap_en = 0;

   // Single node output side
   logic          s_o_valid, s_o_ready, s_o_eor;
   logic [KW-1:0] s_o_key;
   logic [KW:0]   s_got[$];
   logic [KW:0]   s_exp[$];
   int            s_mode = 0;
   int            pulse_cnt = 0;

   // Tree output side
   logic          t_o_valid, t_o_ready, t_o_eor;
   logic [KW-1:0] t_o_key;
   logic [KW:0]   t_got[$];
   logic [KW:0]   t_exp[$];

   logic          l_v, l_r, l_e, r_v, r_r, r_e;
   logic [KW-1:0] l_k, r_k;
   logic          s_a_ready, s_b_ready;

   mtn_node dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_valid(dv[0]), .a_ready(s_a_ready), .a_key(dk[0]), .a_eor(de[0]),
      .b_valid(dv[1]), .b_ready(s_b_ready), .b_key(dk[1]), .b_eor(de[1]),
      .o_valid(s_o_valid), .o_ready(s_o_ready), .o_key(s_o_key), .o_eor(s_o_eor)
   );
   assign rdy[0] = s_a_ready;
   assign rdy[1] = s_b_ready;

   mtn_node tree_l_i (
      .clk(clk), .rst_n(rst_n),
      .a_valid(dv[2]), .a_ready(rdy[2]), .a_key(dk[2]), .a_eor(de[2]),
      .b_valid(dv[3]), .b_ready(rdy[3]), .b_key(dk[3]), .b_eor(de[3]),
      .o_valid(l_v), .o_ready(l_r), .o_key(l_k), .o_eor(l_e)
   );
   mtn_node tree_r_i (
      .clk(clk), .rst_n(rst_n),
      .a_valid(dv[4]), .a_ready(rdy[4]), .a_key(dk[4]), .a_eor(de[4]),
      .b_valid(dv[5]), .b_ready(rdy[5]), .b_key(dk[5]), .b_eor(de[5]),
      .o_valid(r_v), .o_ready(r_r), .o_key(r_k), .o_eor(r_e)
   );
   mtn_node tree_root_i (
      .clk(clk), .rst_n(rst_n),
      .a_valid(l_v), .a_ready(l_r), .a_key(l_k), .a_eor(l_e),
      .b_valid(r_v), .b_ready(r_r), .b_key(r_k), .b_eor(r_e),
      .o_valid(t_o_valid), .o_ready(t_o_ready), .o_key(t_o_key), .o_eor(t_o_eor)
   );

   // Input drivers: ready only changes at rising edges, so the value
   // seen at a falling edge is the one the next rising edge uses.
   initial begin
      for (int i = 0; i < 6; i++) begin
         dv[i] = 1'b0; dk[i] = '0; de[i] = 1'b0; rlat[i] = 1'b0;
      end
   end
   always @(negedge clk) begin
      for (int i = 0; i < 6; i++) begin
         if (dv[i] && rlat[i]) begin
            void'(dq[i].pop_front());
            dv[i] = 1'b0;
         end
         if (!dv[i]) begin
            if (dq[i].size() > 0 && (!gap_en || ($urandom % 4) != 0)) begin
               dv[i] = 1'b1;
               {de[i], dk[i]} = dq[i][0];
            end
         end
         rlat[i] = rdy[i];
      end
   end

   // Output monitors: choose ready, then log the beat the next edge takes.
   initial begin
      s_o_ready = 1'b0;
      t_o_ready = 1'b0;
   end
   always @(negedge clk) begin
      case (s_mode)
         0: s_o_ready = 1'b0;
         1: s_o_ready = 1'b1;
         2: s_o_ready = (($urandom % 3) != 0);
         default: s_o_ready = (pulse_cnt == 0);
      endcase
      pulse_cnt = (s_mode == 3) ? pulse_cnt + 1 : 0;
      if (s_o_valid && s_o_ready) s_got.push_back({s_o_eor, s_o_key});
      t_o_ready = (($urandom % 3) != 0);
      if (t_o_valid && t_o_ready) t_got.push_back({t_o_eor, t_o_key});
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input int i, input logic eor, input logic [KW-1:0] key);
      dq[i].push_back({eor, key});
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic finish_single(input string req);
      int guard = 0;
      while (s_got.size() < s_exp.size() && guard < 20000) begin
         tick();
         guard++;
      end
      repeat (8) tick();
      check(s_got.size() == s_exp.size(), req, "single beat count", s_got.size(), s_exp.size());
      for (int k = 0; k < s_exp.size() && k < s_got.size(); k++)
         check(s_got[k] === s_exp[k], req, $sformatf("single beat %0d", k), s_got[k], s_exp[k]);
      s_got.delete();
      s_exp.delete();
   endtask

   task automatic finish_tree(input string req);
      int guard = 0;
      while (t_got.size() < t_exp.size() && guard < 40000) begin
         tick();
         guard++;
      end
      repeat (12) tick();
      check(t_got.size() == t_exp.size(), req, "tree beat count", t_got.size(), t_exp.size());
      for (int k = 0; k < t_exp.size() && k < t_got.size(); k++)
         check(t_got[k] === t_exp[k], req, $sformatf("tree beat %0d", k), t_got[k], t_exp[k]);
      t_got.delete();
      t_exp.delete();
   endtask

   function automatic logic [KW-1:0] rand_key();
      int r = $urandom % 20;
      if (r == 0) return '0;
      if (r == 1) return '1;
      return KW'($urandom % 12);
   endfunction

   // Builds one random run on stream i; keys are appended to pool.
   task automatic rand_run(input int i, inout logic [KW:0] pool[$]);
      logic [KW:0] run[$];
      int n = $urandom % 7;
      for (int k = 0; k < n; k++) run.push_back({1'b0, rand_key()});
      run.sort();
      foreach (run[k]) begin
         dq[i].push_back(run[k]);
         pool.push_back(run[k]);
      end
      dq[i].push_back(MARK);
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [KW:0] pool[$];
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      tick();

      // R1: idle after reset
      check(s_o_valid == 1'b0, "R1", "o_valid after reset", s_o_valid, 0);
      check(s_a_ready && s_b_ready, "R1", "readies after reset", {s_a_ready, s_b_ready}, 2'b11);

      // R7: warm-up with both inputs accepted on the same edge
      push(0, 0, 1);
      push(1, 0, 2);
      tick();                      // driven, accepted at next edge E
      tick();                      // after E
      check(s_o_valid == 1'b0, "R7", "o_valid after E", s_o_valid, 0);
      tick();                      // after E+1
      check(s_o_valid == 1'b0, "R7", "o_valid after E+1", s_o_valid, 0);
      tick();                      // after E+2
      check(s_o_valid == 1'b1, "R7", "o_valid after E+2", s_o_valid, 1);
      check(s_o_key == 1, "R2", "first head smaller key", s_o_key, 1);

      // R6: held under backpressure
      tick();
      check(s_o_valid && s_o_key == 1 && !s_o_eor, "R6", "output held while stalled",
            {s_o_valid, s_o_key}, {1'b1, 32'd1});

      // R3: fill left buffer beyond two entries
      push(0, 0, 3);
      push(0, 0, 4);
      push(1, 0, 2);
      repeat (5) tick();
      check(s_a_ready == 1'b0, "R3", "a_ready low when full", s_a_ready, 0);
      check(dv[0] == 1'b1 && dq[0].size() == 1, "R3", "third beat held back",
            dq[0].size(), 1);
      push(0, 1, 0);
      push(1, 0, 3);
      push(1, 1, 0);
      s_exp = '{{1'b0, 32'd1}, {1'b0, 32'd2}, {1'b0, 32'd2}, {1'b0, 32'd3},
                {1'b0, 32'd3}, {1'b0, 32'd4}, MARK};
      s_mode = 1;
      finish_single("R3");

      // R4: tie goes to the left input
      s_mode = 0;
      push(0, 0, 5); push(0, 0, 5);
      push(1, 0, 5); push(1, 0, 5);
      repeat (5) tick();
      check(!s_a_ready && !s_b_ready, "R4", "both buffers full", {s_a_ready, s_b_ready}, 2'b00);
      s_mode = 3;
      tick();
      tick();
      check(s_a_ready == 1'b1, "R4", "left slot freed on tie", s_a_ready, 1);
      check(s_b_ready == 1'b0, "R4", "right untouched on tie", s_b_ready, 0);
      push(0, 1, 0);
      push(1, 1, 0);
      s_exp = '{{1'b0, 32'd5}, {1'b0, 32'd5}, {1'b0, 32'd5}, {1'b0, 32'd5}, MARK};
      s_mode = 1;
      finish_single("R4");

      // R5: drain after one marker, one marker out, runs kept apart
      push(0, 0, 1); push(0, 0, 9); push(0, 1, 32'hdead); push(0, 0, 0); push(0, 1, 0);
      push(1, 0, 2); push(1, 0, 3); push(1, 0, 4); push(1, 0, 5); push(1, 1, 7);
      push(1, 0, 7); push(1, 1, 0);
      s_exp = '{{1'b0, 32'd1}, {1'b0, 32'd2}, {1'b0, 32'd3}, {1'b0, 32'd4}, {1'b0, 32'd5},
                {1'b0, 32'd9}, MARK, {1'b0, 32'd0}, {1'b0, 32'd7}, MARK};
      finish_single("R5");

      // R2: unsigned extremes, then an empty run pair (R5)
      push(0, 0, 0); push(0, 0, 32'hffffffff); push(0, 1, 0);
      push(1, 0, 32'hffffffff); push(1, 1, 0);
      push(0, 1, 0); push(1, 1, 0);
      s_exp = '{{1'b0, 32'd0}, {1'b0, 32'hffffffff}, {1'b0, 32'hffffffff}, MARK, MARK};
      finish_single("R2");

      // R2/R6: random runs, gaps and backpressure on one node
      gap_en = 1;
      s_mode = 2;
      for (int r = 0; r < 40; r++) begin
         pool.delete();
         rand_run(0, pool);
         rand_run(1, pool);
         pool.sort();
         foreach (pool[k]) s_exp.push_back(pool[k]);
         s_exp.push_back(MARK);
      end
      finish_single("R2");

      // R8: two-level tree with random traffic
      for (int r = 0; r < 40; r++) begin
         pool.delete();
         for (int i = 2; i < 6; i++) rand_run(i, pool);
         pool.sort();
         foreach (pool[k]) t_exp.push_back(pool[k]);
         t_exp.push_back(MARK);
      end
      finish_tree("R8");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule